// File: doc/BRIEF.md
# Atomic RMW Address Lock Filter

This block guards a cache coherence controller while an atomic read-modify-write is in progress. The controller drains several input queues: one core request port and a set of network request and response ports. When the read half of an atomic completes, the block records the line address in a small lock table and binds it to the core port. The lock stays in place until the write half of the same atomic completes. While a line is locked, a head message on any other port that targets that line is not accepted. The port sees ready low and a defer strobe, and the queue keeps the message and presents it again on the next cycle. Nothing is discarded.

The lock does not depend on the coherence protocol. It is a fully associative compare of each port's head line address against every valid entry, done in the same cycle. Several lines can be held at once, so an atomic that spans lines works, provided its locks are always taken in the same address order. A summary flag shows whether any lock is held. Two error strobes report a lock that finds no free entry and an unlock that names no held line.

Top module: `atomicLockFilter`

## Requirements
- R1: While reset is asserted, and after it is released, the table is empty: blocking is 0, both error strobes are 0, and every port has ready 1 and defer 0, whatever the head addresses are.
- R2: A lock request (lockReq=1, unlockReq=0) for a line that has no entry, with a free entry available, takes that entry at the next rising edge, with the core port as owner. blocking reads 1 from that edge on.
- R3: While a line is locked, a valid head on a network port whose line matches it has netReady=0 and netDefer=1 in that same cycle. The port is judged again on every cycle, so the message stays deferred until the lock is removed.
- R4: A valid core-port head is never deferred. The core port owns every lock, so it passes even for a locked line.
- R5: A head whose line matches no valid entry passes at once (ready 1, defer 0) on any port.
- R6: Matching compares the full LINE_W-bit line address. A line that differs from a locked line in any bit, including the most significant one, is not held back.
- R7: An unlock request (unlockReq=1, lockReq=0) for a held line frees its entry at the next rising edge. Heads for that line pass from that edge on. blocking falls only once the last entry is freed.
- R8: Up to ENTRIES (default 4) distinct lines can be locked at the same time. Each one defers non-owner heads on its own.
- R9: A lock request for a new line while all entries are in use drives overflowErr=1 in that cycle and leaves the table unchanged.
- R10: An unlock request for a line that is not held drives protoErr=1 in that cycle and leaves the table unchanged.
- R11: A lock request for a line that is already held adds no entry and raises no error, even when the table is full. A single unlock then frees it.
- R12: lockReq and unlockReq asserted in the same cycle drive protoErr=1 and leave the table unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| coreValid | input | 1 | Core port head message present |
| coreLine | input | LINE_W | Line address of the core port head |
| coreReady | output | 1 | Core head may be serviced this cycle |
| coreDefer | output | 1 | Core head is deferred this cycle |
| netValid | input | NUM_NET | Head present, one bit per network port |
| netLine | input | NUM_NET x LINE_W | Line address of each network port head |
| netReady | output | NUM_NET | Network head may be serviced this cycle |
| netDefer | output | NUM_NET | Network head deferred and re-queued this cycle |
| lockReq | input | 1 | Read half of an atomic has completed for opLine |
| unlockReq | input | 1 | Write half of an atomic has completed for opLine |
| opLine | input | LINE_W | Line address of the lock or unlock operation |
| blocking | output | 1 | At least one lock entry is held |
| overflowErr | output | 1 | Lock request found the table full |
| protoErr | output | 1 | Unlock of an unheld line, or lock and unlock in the same cycle |

## Verification
Ready, defer and both error strobes are combinational, so they are due in the same cycle as the stimulus, and they always reflect the table as it stood before the coming edge. Table changes (a new lock, a freed entry, the blocking flag) are due one rising edge after the request. The bench drives each stimulus at a falling edge and samples 1 ns before the next rising edge. It therefore sees the same-cycle results of a request together with the effects of all earlier ones, never the effect of the request itself. Vectors that follow a lock or an unlock then confirm the change one cycle later.

// File: rtl/atomicLockPkg.sv
package atomicLockPkg;
  // widest entry index the strobe struct can carry (ENTRIES <= 2**LK_IDX_MAX_W)
  localparam int LK_IDX_MAX_W = 4;

  typedef struct packed {
    logic                    setEn;
    logic                    clrEn;
    logic [LK_IDX_MAX_W-1:0] setIdx;
    logic [LK_IDX_MAX_W-1:0] clrIdx;
  } lockStrobe_t;
endpackage

// File: rtl/lockCtrl.sv
module lockCtrl
  import atomicLockPkg::*;
#(
  parameter int ENTRIES = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               lockReq,
  input  logic               unlockReq,
  input  logic [ENTRIES-1:0] opHit,
  input  logic [ENTRIES-1:0] entValid,
  output lockStrobe_t        strobe,
  output logic               overflowErr,
  output logic               protoErr
);
  logic [LK_IDX_MAX_W-1:0] freeIdx;
  logic [LK_IDX_MAX_W-1:0] hitIdx;
  logic anyHit;
  logic tableFull;
  logic bothReq;
  logic lockOnly;
  logic unlockOnly;

  // lowest free slot and the matching slot; descending loop so index 0 wins
  always_comb begin
    freeIdx = '0;
    hitIdx  = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!entValid[i]) freeIdx = LK_IDX_MAX_W'(i);
      if (opHit[i])     hitIdx  = LK_IDX_MAX_W'(i);
    end
  end

  assign anyHit     = |opHit;
  assign tableFull  = &entValid;
  assign bothReq    = lockReq && unlockReq;
  assign lockOnly   = lockReq && !unlockReq;
  assign unlockOnly = unlockReq && !lockReq;

  always_comb begin
    strobe        = '0;
    strobe.setEn  = lockOnly && !anyHit && !tableFull;
    strobe.setIdx = freeIdx;
    strobe.clrEn  = unlockOnly && anyHit;
    strobe.clrIdx = hitIdx;
  end

  assign overflowErr = lockOnly && !anyHit && tableFull;
  assign protoErr    = bothReq || (unlockOnly && !anyHit);

  // R9
  overflow_keeps_table_chk: assert property (@(posedge clk) disable iff (!rstN)
    overflowErr |=> $stable(entValid));

  // R10
  proto_keeps_table_chk: assert property (@(posedge clk) disable iff (!rstN)
    protoErr |=> $stable(entValid));
endmodule

// File: rtl/lockTable.sv
module lockTable
  import atomicLockPkg::*;
#(
  parameter int ENTRIES   = 4,
  parameter int LINE_W    = 26,
  parameter int NUM_PORTS = 3,
  parameter int CORE_PORT = 0,
  localparam int PID_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  lockStrobe_t                      strobe,
  input  logic [LINE_W-1:0]                opLine,
  input  logic [NUM_PORTS-1:0][LINE_W-1:0] portLine,
  input  logic [NUM_PORTS-1:0]             portValid,
  output logic [ENTRIES-1:0]               opHit,
  output logic [ENTRIES-1:0]               entValid,
  output logic [NUM_PORTS-1:0]             portReady,
  output logic [NUM_PORTS-1:0]             portDefer,
  output logic                             blocking
);
  logic [LINE_W-1:0] tagArr   [ENTRIES];
  logic [PID_W-1:0]  ownerArr [ENTRIES];

  for (genvar i = 0; i < ENTRIES; i++) begin : gEnt
    logic              vQ;
    logic [LINE_W-1:0] tagQ;
    logic [PID_W-1:0]  ownQ;
    logic              setHere;
    logic              clrHere;

    assign setHere = strobe.setEn && (strobe.setIdx == LK_IDX_MAX_W'(i));
    assign clrHere = strobe.clrEn && (strobe.clrIdx == LK_IDX_MAX_W'(i));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        vQ   <= 1'b0;
        tagQ <= '0;
        ownQ <= '0;
      end else if (setHere) begin
        vQ   <= 1'b1;
        tagQ <= opLine;
        ownQ <= PID_W'(CORE_PORT);
      end else if (clrHere) begin
        vQ   <= 1'b0;
      end
    end

    assign entValid[i] = vQ;
    assign tagArr[i]   = tagQ;
    assign ownerArr[i] = ownQ;
    assign opHit[i]    = vQ && (tagQ == opLine);

    // R2
    set_into_free_chk: assert property (@(posedge clk) disable iff (!rstN)
      setHere |-> !vQ);

    // R7
    clear_held_only_chk: assert property (@(posedge clk) disable iff (!rstN)
      clrHere |-> vQ);
  end

  // per-port conflict: a held line owned by some other port
  for (genvar p = 0; p < NUM_PORTS; p++) begin : gPort
    logic [ENTRIES-1:0] conflict;
    for (genvar i = 0; i < ENTRIES; i++) begin : gCmp
      assign conflict[i] = entValid[i] && (tagArr[i] == portLine[p])
                           && (ownerArr[i] != PID_W'(p));
    end
    assign portDefer[p] = portValid[p] && (|conflict);
    assign portReady[p] = !portDefer[p];
  end

  assign blocking = |entValid;

  // R2
  lock_sets_blocking_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.setEn |=> blocking);

  // R11
  unique_tag_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones(opHit) <= 1);
endmodule

// File: rtl/atomicLockFilter.sv
module atomicLockFilter
  import atomicLockPkg::*;
#(
  parameter int ENTRIES   = 4,
  parameter int LINE_W    = 26,
  parameter int NUM_NET   = 2,
  localparam int NUM_PORTS = NUM_NET + 1
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           coreValid,
  input  logic [LINE_W-1:0]              coreLine,
  output logic                           coreReady,
  output logic                           coreDefer,
  input  logic [NUM_NET-1:0]             netValid,
  input  logic [NUM_NET-1:0][LINE_W-1:0] netLine,
  output logic [NUM_NET-1:0]             netReady,
  output logic [NUM_NET-1:0]             netDefer,
  input  logic                           lockReq,
  input  logic                           unlockReq,
  input  logic [LINE_W-1:0]              opLine,
  output logic                           blocking,
  output logic                           overflowErr,
  output logic                           protoErr
);
  lockStrobe_t                      strobe;
  logic [ENTRIES-1:0]               opHit;
  logic [ENTRIES-1:0]               entValid;
  logic [NUM_PORTS-1:0][LINE_W-1:0] portLine;
  logic [NUM_PORTS-1:0]             portValid;
  logic [NUM_PORTS-1:0]             portReady;
  logic [NUM_PORTS-1:0]             portDefer;

  // port 0 is the core port, network ports follow
  assign portLine  = {netLine, coreLine};
  assign portValid = {netValid, coreValid};

  lockCtrl #(.ENTRIES(ENTRIES)) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .lockReq    (lockReq),
    .unlockReq  (unlockReq),
    .opHit      (opHit),
    .entValid   (entValid),
    .strobe     (strobe),
    .overflowErr(overflowErr),
    .protoErr   (protoErr)
  );

  lockTable #(
    .ENTRIES  (ENTRIES),
    .LINE_W   (LINE_W),
    .NUM_PORTS(NUM_PORTS),
    .CORE_PORT(0)
  ) table_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .opLine   (opLine),
    .portLine (portLine),
    .portValid(portValid),
    .opHit    (opHit),
    .entValid (entValid),
    .portReady(portReady),
    .portDefer(portDefer),
    .blocking (blocking)
  );

  assign coreReady = portReady[0];
  assign coreDefer = portDefer[0];
  assign netReady  = portReady[NUM_PORTS-1:1];
  assign netDefer  = portDefer[NUM_PORTS-1:1];

  // R4
  core_never_held_chk: assert property (@(posedge clk) disable iff (!rstN)
    coreValid |-> coreReady);
endmodule

// File: tb/atomicLockFilter_tb.sv
module atomicLockFilter_tb_top;
  localparam int LW = 26;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic coreValid, coreReady, coreDefer;
  logic [LW-1:0] coreLine;
  logic [1:0] netValid, netReady, netDefer;
  logic [1:0][LW-1:0] netLine;
  logic lockReq, unlockReq;
  logic [LW-1:0] opLine;
  logic blocking, overflowErr, protoErr;

  always #2 clk = ~clk; // 250 MHz

  atomicLockFilter #(.ENTRIES(4), .LINE_W(LW), .NUM_NET(2)) dut_i (
    .clk(clk), .rstN(rstN),
    .coreValid(coreValid), .coreLine(coreLine), .coreReady(coreReady), .coreDefer(coreDefer),
    .netValid(netValid), .netLine(netLine), .netReady(netReady), .netDefer(netDefer),
    .lockReq(lockReq), .unlockReq(unlockReq), .opLine(opLine),
    .blocking(blocking), .overflowErr(overflowErr), .protoErr(protoErr)
  );

  typedef struct packed {
    logic          lk;
    logic          ul;
    logic [LW-1:0] op;
    logic          cv;
    logic [LW-1:0] ca;
    logic          n0v;
    logic [LW-1:0] n0a;
    logic          n1v;
    logic [LW-1:0] n1a;
    logic          eCR;
    logic          eN0R;
    logic          eN1R;
    logic          eBlk;
    logic          eOvf;
    logic          ePro;
    logic [7:0]    req;
  } vec_t;

  // outputs sampled before the edge that applies the vector's lock/unlock
  localparam vec_t VECS [17] = '{
    // R5 empty table, everything passes
    '{1'b0,1'b0,26'h0,  1'b1,26'h100, 1'b1,26'h100, 1'b1,26'h101, 1'b1,1'b1,1'b1,1'b0,1'b0,1'b0, 8'd5},
    // R2 lock 0x100, not yet visible
    '{1'b1,1'b0,26'h100,1'b0,26'h0,   1'b1,26'h100, 1'b0,26'h0,   1'b1,1'b1,1'b1,1'b0,1'b0,1'b0, 8'd2},
    // R3 net0 held on 0x100, core passes (R4)
    '{1'b0,1'b0,26'h0,  1'b1,26'h100, 1'b1,26'h100, 1'b1,26'h101, 1'b1,1'b0,1'b1,1'b1,1'b0,1'b0, 8'd3},
    // R3 lock 0x101, net1 held on 0x100
    '{1'b1,1'b0,26'h101,1'b0,26'h0,   1'b0,26'h0,   1'b1,26'h100, 1'b1,1'b1,1'b0,1'b1,1'b0,1'b0, 8'd3},
    // R6 0x101 held, top-bit variant of 0x100 passes
    '{1'b0,1'b0,26'h0,  1'b1,26'h101, 1'b1,26'h101, 1'b1,26'h2000100, 1'b1,1'b0,1'b1,1'b1,1'b0,1'b0, 8'd6},
    // R8 lock 0x102
    '{1'b1,1'b0,26'h102,1'b0,26'h0,   1'b0,26'h0,   1'b0,26'h0,   1'b1,1'b1,1'b1,1'b1,1'b0,1'b0, 8'd8},
    // R8 lock 0x103
    '{1'b1,1'b0,26'h103,1'b0,26'h0,   1'b0,26'h0,   1'b0,26'h0,   1'b1,1'b1,1'b1,1'b1,1'b0,1'b0, 8'd8},
    // R9 lock 0x104 into full table
    '{1'b1,1'b0,26'h104,1'b0,26'h0,   1'b1,26'h104, 1'b1,26'h102, 1'b1,1'b1,1'b0,1'b1,1'b1,1'b0, 8'd9},
    // R9 0x104 not added, 0x103 held
    '{1'b0,1'b0,26'h0,  1'b0,26'h0,   1'b1,26'h104, 1'b1,26'h103, 1'b1,1'b1,1'b0,1'b1,1'b0,1'b0, 8'd9},
    // R11 relock 0x100 while full: no error
    '{1'b1,1'b0,26'h100,1'b0,26'h0,   1'b1,26'h100, 1'b0,26'h0,   1'b1,1'b0,1'b1,1'b1,1'b0,1'b0, 8'd11},
    // R10 unlock of unheld 0x104
    '{1'b0,1'b1,26'h104,1'b0,26'h0,   1'b0,26'h0,   1'b0,26'h0,   1'b1,1'b1,1'b1,1'b1,1'b0,1'b1, 8'd10},
    // R12 lock and unlock together
    '{1'b1,1'b1,26'h100,1'b0,26'h0,   1'b1,26'h100, 1'b0,26'h0,   1'b1,1'b0,1'b1,1'b1,1'b0,1'b1, 8'd12},
    // R7 0x100 still held after R12; unlock it now
    '{1'b0,1'b1,26'h100,1'b0,26'h0,   1'b1,26'h100, 1'b0,26'h0,   1'b1,1'b0,1'b1,1'b1,1'b0,1'b0, 8'd7},
    // R7 0x100 free after one unlock (R11), 0x101 still held
    '{1'b0,1'b1,26'h101,1'b0,26'h0,   1'b1,26'h100, 1'b1,26'h101, 1'b1,1'b1,1'b0,1'b1,1'b0,1'b0, 8'd7},
    // R7 unlock 0x102
    '{1'b0,1'b1,26'h102,1'b0,26'h0,   1'b1,26'h101, 1'b0,26'h0,   1'b1,1'b1,1'b1,1'b1,1'b0,1'b0, 8'd7},
    // R7 unlock last (0x103), blocking still high this cycle
    '{1'b0,1'b1,26'h103,1'b0,26'h0,   1'b0,26'h0,   1'b1,26'h103, 1'b1,1'b1,1'b0,1'b1,1'b0,1'b0, 8'd7},
    // R7 table empty, blocking low
    '{1'b0,1'b0,26'h0,  1'b0,26'h0,   1'b0,26'h0,   1'b1,26'h103, 1'b1,1'b1,1'b1,1'b0,1'b0,1'b0, 8'd7}
  };

  int nChecks = 0;
  int nFail = 0;
  bit done = 1'b0;

  function automatic string reqName(input int r);
    case (r)
      1: return "R1";   2: return "R2";   3: return "R3";   4: return "R4";
      5: return "R5";   6: return "R6";   7: return "R7";   8: return "R8";
      9: return "R9";   10: return "R10"; 11: return "R11"; 12: return "R12";
      default: return "R?";
    endcase
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    lockReq = 1'b0; unlockReq = 1'b0; opLine = '0;
    coreValid = 1'b0; coreLine = '0; netValid = '0; netLine = '0;
  endtask

  initial begin
    idle();
    repeat (3) @(posedge clk);
    // R1 during reset, with heads on a line
    @(negedge clk);
    netValid = 2'b11; netLine[0] = 26'h100; netLine[1] = 26'h100;
    #1;
    chk("R1", "blocking in reset", 32'(blocking), 32'd0);
    chk("R1", "netReady in reset", 32'(netReady), 32'h3);
    rstN = 1'b1;
    #0.5;
    chk("R1", "netDefer after reset", 32'(netDefer), 32'd0);
    chk("R1", "overflowErr after reset", 32'(overflowErr), 32'd0);
    chk("R1", "protoErr after reset", 32'(protoErr), 32'd0);

    foreach (VECS[k]) begin
      @(negedge clk);
      lockReq = VECS[k].lk; unlockReq = VECS[k].ul; opLine = VECS[k].op;
      coreValid = VECS[k].cv; coreLine = VECS[k].ca;
      netValid = {VECS[k].n1v, VECS[k].n0v};
      netLine[0] = VECS[k].n0a; netLine[1] = VECS[k].n1a;
      #1;
      chk(reqName(int'(VECS[k].req)), $sformatf("v%0d coreReady", k), 32'(coreReady), 32'(VECS[k].eCR));
      chk(reqName(int'(VECS[k].req)), $sformatf("v%0d coreDefer", k), 32'(coreDefer), 32'(VECS[k].cv & ~VECS[k].eCR));
      chk(reqName(int'(VECS[k].req)), $sformatf("v%0d netReady", k), 32'(netReady), 32'({VECS[k].eN1R, VECS[k].eN0R}));
      chk(reqName(int'(VECS[k].req)), $sformatf("v%0d netDefer", k), 32'(netDefer),
          32'({VECS[k].n1v & ~VECS[k].eN1R, VECS[k].n0v & ~VECS[k].eN0R}));
      chk(reqName(int'(VECS[k].req)), $sformatf("v%0d blocking", k), 32'(blocking), 32'(VECS[k].eBlk));
      chk(reqName(int'(VECS[k].req)), $sformatf("v%0d overflowErr", k), 32'(overflowErr), 32'(VECS[k].eOvf));
      chk(reqName(int'(VECS[k].req)), $sformatf("v%0d protoErr", k), 32'(protoErr), 32'(VECS[k].ePro));
    end

    // R3 held head stays deferred over several cycles
    @(negedge clk);
    idle(); lockReq = 1'b1; opLine = 26'h200;
    @(negedge clk);
    idle(); netValid = 2'b01; netLine[0] = 26'h200;
    for (int c = 0; c < 3; c++) begin
      #1;
      chk("R3", "repeat defer", 32'(netDefer), 32'h1);
      @(negedge clk);
    end

    // R1 asynchronous reset clears the held lock
    rstN = 1'b0;
    #1;
    chk("R1", "blocking cleared by reset", 32'(blocking), 32'd0);
    chk("R1", "netReady after reset", 32'(netReady), 32'h3);
    @(negedge clk);
    rstN = 1'b1;
    idle();
    @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
      $finish;
    end
  end
endmodule